// File: doc/BRIEF.md
# SECDED Protected Word Store with Fault Injection

This block guards a small word-addressed store with a 72-bit single-error-correct, double-error-detect code. Each 64-bit write is turned into a 72-bit codeword with eight check bits and placed in a plain 72-bit memory. Each read fetches the codeword, computes a syndrome, repairs any single flipped bit on its way to the output, and flags a double flip as uncorrectable. Repairs happen only on the output path. The stored codeword is never rewritten.

Codeword layout: bit index equals Hamming position. Bit 0 holds overall parity. Bits 1, 2, 4, 8, 16, 32 and 64 hold the seven Hamming checks. The 64 data bits fill the remaining positions 3..71 in ascending order. A zero syndrome with even overall parity means a clean word. Odd overall parity with a syndrome that names a position inside the word means a correctable single error; a zero syndrome in that case names bit 0. Even overall parity with a nonzero syndrome means a double error. Odd parity with a syndrome outside the word is also reported as a double error.

Two test inputs damage the codeword as it is written: one flips bit 0, the other flips bits 0 and 1. The read address of the most recent flagged word is kept on an output for software-free fault logging.

Top module: `secded_ecc`

## Requirements
- R1: A word written without injection and read back appears unchanged on `rd_data_o`, with both error flags low.
- R2: A read requested in cycle n produces `rd_valid_o`, `rd_data_o` and the flags after the second rising edge (latency 2). `rd_data_o` holds its value while `rd_valid_o` is low, and the flags are low whenever `rd_valid_o` is low.
- R3: A word written with `inj_single_i` high (codeword bit 0 flipped) reads back with the original data, `err_single_o` high and `err_double_o` low.
- R4: A word written with `inj_double_i` high (codeword bits 0 and 1 flipped) reads back with `err_double_o` high and `err_single_o` low. `rd_data_o` carries the uncorrected data bits, which for this fault equal the written data.
- R5: On every flagged read, `err_addr_o` takes that read's address in the same cycle as the flag. It holds through clean reads until the next flagged read.
- R6: When both inject inputs are high on a write, the double fault is applied.
- R7: The inject inputs have no effect in a cycle without `wr_en_i`. Nothing carries over to a later write.
- R8: Correction does not alter the stored codeword, so a damaged word is flagged again on every read.
- R9: A read and a write to the same address in the same cycle return the contents held before that write.
- R10: After reset, `rd_valid_o`, both flags, `rd_data_o` and `err_addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 64 | Write data |
| inj_single_i | input | 1 | Flip codeword bit 0 on this write |
| inj_double_i | input | 1 | Flip codeword bits 0 and 1 on this write |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Corrected read data |
| err_single_o | output | 1 | Single error corrected on this result |
| err_double_o | output | 1 | Uncorrectable error on this result |
| err_addr_o | output | ADDR_W | Address of the last flagged read |

## Verification
The assertions assume that every read targets an address that has been written since reset, so the codeword held there is defined. They also assume the inject inputs and strobes are never unknown after reset. The stimulus writes every address before its first read and drives every input to a known level from time zero. It then reaches each fault type, the inject-without-write case and the same-address collision through legal port sequences only.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CODE_W = 72;

  typedef enum logic [1:0] {ERR_NONE, ERR_SINGLE, ERR_DOUBLE} err_kind_e;

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword index of data bit i (non power-of-two positions, ascending)
  function automatic int data_pos(int i);
    int cnt = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == i) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // positions covered by Hamming check k
  function automatic logic [CODE_W-1:0] ham_mask(int k);
    logic [CODE_W-1:0] m = '0;
    for (int p = 1; p < CODE_W; p++) m[p] = ((p >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] cw_o
);
  logic [CODE_W-1:0] base;
  logic [HAM_W-1:0]  chk;
  logic [CODE_W-1:0] body;

  assign base[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_place
    localparam int P = data_pos(i);
    assign base[P] = data_i[i];
  end
  for (genvar k = 0; k < HAM_W; k++) begin : g_chk
    localparam logic [CODE_W-1:0] M = ham_mask(k);
    assign base[1 << k] = 1'b0;
    assign chk[k] = ^(base & M);
  end

  always_comb begin
    body = base;
    for (int k = 0; k < HAM_W; k++) body = body | (CODE_W'(chk[k]) << (1 << k));
  end

  // overall parity over the whole word lands in bit 0
  assign cw_o = {body[CODE_W-1:1], ^body};
endmodule

// File: rtl/secded_inj.sv
module secded_inj
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] cw_i,
  input  logic              single_i,
  input  logic              double_i,
  output logic [CODE_W-1:0] cw_o
);
  logic [1:0] flip;

  always_comb begin
    if (double_i)      flip = 2'b11;
    else if (single_i) flip = 2'b01;
    else               flip = 2'b00;
  end

  assign cw_o = {cw_i[CODE_W-1:2], cw_i[1:0] ^ flip};
endmodule

// File: rtl/secded_mem.sv
module secded_mem #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 72
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WIDTH-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // read-first on address collision
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] cw_i,
  output logic [DATA_W-1:0] data_o,
  output err_kind_e         kind_o
);
  logic [HAM_W-1:0] synd;
  logic             odd;
  logic             in_range;
  logic             fix;

  for (genvar k = 0; k < HAM_W; k++) begin : g_syn
    localparam logic [CODE_W-1:0] M = ham_mask(k);
    assign synd[k] = ^(cw_i & M);
  end

  assign odd      = ^cw_i;
  assign in_range = int'(synd) < CODE_W;
  assign fix      = odd && in_range;

  always_comb begin
    if (fix)                    kind_o = ERR_SINGLE;
    else if (odd || synd != 0)  kind_o = ERR_DOUBLE;
    else                        kind_o = ERR_NONE;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_out
    localparam int P = data_pos(i);
    assign data_o[i] = cw_i[P] ^ (fix && (synd == HAM_W'(P)));
  end
endmodule

// File: rtl/secded_ecc.sv
module secded_ecc
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [63:0]       wr_data_i,
  input  logic              inj_single_i,
  input  logic              inj_double_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [63:0]       rd_data_o,
  output logic              err_single_o,
  output logic              err_double_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  logic [CODE_W-1:0] enc_cw;
  logic [CODE_W-1:0] wr_cw;
  logic [CODE_W-1:0] rd_cw;
  logic [DATA_W-1:0] dec_data;
  err_kind_e         dec_kind;
  logic              rd_v1;
  logic [ADDR_W-1:0] rd_a1;

  secded_enc u_enc (.data_i(wr_data_i), .cw_o(enc_cw));

  secded_inj u_inj (
    .cw_i    (enc_cw),
    .single_i(inj_single_i & wr_en_i),
    .double_i(inj_double_i & wr_en_i),
    .cw_o    (wr_cw)
  );

  secded_mem #(.ADDR_W(ADDR_W), .WIDTH(CODE_W)) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_cw),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_cw)
  );

  secded_dec u_dec (.cw_i(rd_cw), .data_o(dec_data), .kind_o(dec_kind));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v1 <= 1'b0;
      rd_a1 <= '0;
    end else begin
      rd_v1 <= rd_en_i;
      if (rd_en_i) rd_a1 <= rd_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      err_single_o <= 1'b0;
      err_double_o <= 1'b0;
      err_addr_o   <= '0;
    end else begin
      rd_valid_o   <= rd_v1;
      err_single_o <= rd_v1 && (dec_kind == ERR_SINGLE);
      err_double_o <= rd_v1 && (dec_kind == ERR_DOUBLE);
      if (rd_v1) rd_data_o <= dec_data;
      if (rd_v1 && dec_kind != ERR_NONE) err_addr_o <= rd_a1;
    end
  end
endmodule

// File: rtl/secded_ecc_chk.sv
module secded_ecc_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_valid_o,
  input logic [63:0]       rd_data_o,
  input logic              err_single_o,
  input logic              err_double_o,
  input logic [ADDR_W-1:0] err_addr_o
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_single_o && err_double_o)); // R4
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_single_o || err_double_o) |-> rd_valid_o); // R2
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> ##1 rd_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ##1 !rd_valid_o); // R2
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> $stable(rd_data_o)); // R2
  AST_ERR_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_single_o || err_double_o) |-> $stable(err_addr_o)); // R5
  AST_ERR_ADDR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_single_o || err_double_o) |-> err_addr_o == $past(rd_addr_i, 2)); // R5
endmodule

bind secded_ecc secded_ecc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .err_single_o(err_single_o),
  .err_double_o(err_double_o),
  .err_addr_o  (err_addr_o)
);

// File: tb/secded_ecc_test.sv
`timescale 1ns/1ps
module secded_ecc_test;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic          inj_s = 1'b0;
  logic          inj_d = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic          err_s;
  logic          err_d;
  logic [AW-1:0] err_addr;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  secded_ecc #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .inj_single_i(inj_s), .inj_double_i(inj_d),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .err_single_o(err_s), .err_double_o(err_d),
    .err_addr_o(err_addr)
  );

  // behavioural reference: stored data plus fault kind (0 clean, 1 single, 2 double)
  logic [63:0]   m_data [DEPTH];
  int            m_kind [DEPTH];
  logic          s1_v;
  logic [63:0]   s1_d;
  int            s1_k;
  logic [AW-1:0] s1_a;
  logic          e_v;
  logic [63:0]   e_d;
  logic          e_s, e_dd;
  logic [AW-1:0] e_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 0; s1_d <= '0; s1_k <= 0; s1_a <= '0;
      e_v <= 0; e_d <= '0; e_s <= 0; e_dd <= 0; e_a <= '0;
    end else begin
      s1_v <= rd_en;
      if (rd_en) begin
        s1_d <= m_data[rd_addr];
        s1_k <= m_kind[rd_addr];
        s1_a <= rd_addr;
      end
      e_v  <= s1_v;
      e_s  <= s1_v && s1_k == 1;
      e_dd <= s1_v && s1_k == 2;
      if (s1_v) e_d <= s1_d;
      if (s1_v && s1_k != 0) e_a <= s1_a;
      if (wr_en) begin
        m_data[wr_addr] <= wr_data;
        m_kind[wr_addr] <= inj_d ? 2 : (inj_s ? 1 : 0);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_valid == e_v, "R2", "rd_valid", 64'(rd_valid), 64'(e_v));
      chk(rd_data == e_d, cur_req, "rd_data", rd_data, e_d);
      chk(err_s == e_s, cur_req, "err_single", 64'(err_s), 64'(e_s));
      chk(err_d == e_dd, cur_req, "err_double", 64'(err_d), 64'(e_dd));
      chk(err_addr == e_a, "R5", "err_addr", 64'(err_addr), 64'(e_a));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; inj_s = 0; inj_d = 0;
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [63:0] d, bit s, bit dd);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; inj_s = s; inj_d = dd; rd_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 0; inj_s = 0; inj_d = 0; rd_en = 1; rd_addr = a;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'h1d87_2b41_9c3e_f005;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rd_valid == 0, "R10", "rd_valid", 64'(rd_valid), 0);
    chk(rd_data == 0, "R10", "rd_data", rd_data, 0);
    chk(err_s == 0 && err_d == 0, "R10", "flags", {62'b0, err_s, err_d}, 0);
    chk(err_addr == 0, "R10", "err_addr", 64'(err_addr), 0);
    rst_n = 1;

    // R1 clean patterns
    cur_req = "R1";
    wr(0, 64'h0, 0, 0);
    wr(1, '1, 0, 0);
    wr(2, 64'haaaa_aaaa_aaaa_aaaa, 0, 0);
    wr(3, 64'h5555_5555_5555_5555, 0, 0);
    for (int i = 4; i < DEPTH; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      wr(AW'(i), (i < 8) ? (64'h1 << (i * 9)) : lfsr, 0, 0);
    end
    for (int i = 0; i < DEPTH; i++) rd(AW'(i));
    idle(3);

    // R3 single fault
    cur_req = "R3";
    wr(3, 64'hdead_beef_0123_4567, 1, 0);
    rd(3);
    idle(3);
    chk(err_addr == 3, "R3", "err_addr after single", 64'(err_addr), 3);

    // R5 clean read keeps the logged address
    cur_req = "R5";
    rd(1);
    idle(3);
    chk(err_addr == 3, "R5", "err_addr hold", 64'(err_addr), 3);

    // R4 double fault
    cur_req = "R4";
    wr(5, 64'hfeed_face_cafe_f00d, 0, 1);
    rd(5);
    idle(3);
    chk(err_d == 0, "R4", "double flag drops", 64'(err_d), 0);
    chk(err_addr == 5, "R4", "err_addr after double", 64'(err_addr), 5);

    // R6 both inject inputs
    cur_req = "R6";
    wr(7, 64'h0f0f_0f0f_f0f0_f0f0, 1, 1);
    rd(7);
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    chk(err_d == 1 && err_s == 0, "R6", "double wins", {62'b0, err_s, err_d}, 64'h1);
    idle(2);

    // R7 inject without write, then clean write
    cur_req = "R7";
    @(negedge clk); wr_en = 0; rd_en = 0; inj_s = 1; inj_d = 1;
    wr(9, 64'h1234_5678_9abc_def0, 0, 0);
    rd(9);
    rd(0);
    idle(3);

    // R8 damaged words stay damaged
    cur_req = "R8";
    rd(3);
    rd(5);
    rd(3);
    idle(3);
    chk(err_addr == 3, "R8", "re-flag addr", 64'(err_addr), 3);

    // R9 same-address read and write
    cur_req = "R9";
    @(negedge clk);
    wr_en = 1; wr_addr = 2; wr_data = 64'h7777_0000_1111_2222; inj_s = 0; inj_d = 0;
    rd_en = 1; rd_addr = 2;
    @(negedge clk); wr_en = 0; rd_en = 0;
    @(negedge clk);
    chk(rd_data == 64'haaaa_aaaa_aaaa_aaaa, "R9", "old data", rd_data, 64'haaaa_aaaa_aaaa_aaaa);
    rd(2);
    idle(3);

    // R2 back-to-back mixed reads
    cur_req = "R2";
    for (int i = 0; i < 24; i++) rd(AW'(i * 5));
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule